// File: doc/BRIEF.md
# Restoring Array Divider

This block divides an unsigned dividend by an unsigned divisor in one combinational pass. It has no clock and holds no state. A quotient and a remainder appear as soon as the operands settle. The datapath is a grid of identical cells: one row for each dividend bit, and one column for each bit of the widened partial remainder.

Row zero starts from a partial remainder of zero. Each row shifts in the next dividend bit, most significant bit first, and tries to subtract the divisor. If the subtraction leaves no borrow, the row keeps the difference and its quotient bit is 1. If the subtraction borrows, the row keeps the shifted value as it was and its quotient bit is 0. The last row's output is the remainder.

A zero divisor is not detected by the grid. A separate flag reports it, and the quotient and remainder are then don't-care. The cell count grows with the product of the two widths, so the block suits operands of about 16 bits or narrower.

Top module: `rad_divider`

## Requirements
- R1: For every nonzero divisor, `quotient` equals the integer quotient of `dividend` divided by `divisor`, rounded toward zero.
- R2: For every nonzero divisor, `remainder` equals `dividend` modulo `divisor`.
- R3: For every nonzero divisor, `remainder` is strictly less than `divisor`.
- R4: `div_zero` is 1 exactly when every bit of `divisor` is 0, and 0 otherwise. When it is 1, `quotient` and `remainder` carry no meaning.
- R5: A divisor of 1 gives `quotient` equal to `dividend` and a `remainder` of 0.
- R6: A dividend smaller than a nonzero divisor gives a `quotient` of 0 and a `remainder` equal to the dividend.
- R7: Outputs follow the operands with no clock: a new operand pair shows its result without any clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend | input | NUM_W (8) | Unsigned dividend |
| divisor | input | DEN_W (4) | Unsigned divisor |
| quotient | output | NUM_W (8) | Unsigned quotient, most significant bit from the first row |
| remainder | output | DEN_W (4) | Unsigned remainder from the last row |
| div_zero | output | 1 | High when the divisor is zero |

## Verification
A wrong borrow or a wrong restore choice in a row flips that row's quotient bit. It also corrupts the partial remainder that every later row inherits. The error therefore shows up on the ports in the same evaluation, either as a wrong quotient bit or as a remainder at or above the divisor, and nothing holds it back until a later clock. Every dividend and divisor pair is applied, together with directed corners and a seeded random pass. A fault in any single cell therefore changes at least one visible result.

// File: rtl/rad_pkg.sv
package rad_pkg;

    typedef struct packed {
        logic diff;
        logic bout;
    } rad_sub_t;

    function automatic rad_sub_t rad_sub(input logic a, input logic b, input logic bin);
        rad_sub_t r;
        r.diff = a ^ b ^ bin;
        r.bout = (~a & b) | (~a & bin) | (b & bin);
        return r;
    endfunction

endpackage

// File: rtl/rad_cell.sv
module rad_cell
    import rad_pkg::*;
(
    input  logic rem_in,
    input  logic den_bit,
    input  logic borrow_in,
    input  logic keep,
    output logic borrow_out,
    output logic rem_out
);
    rad_sub_t sub;

    always_comb begin
        sub        = rad_sub(rem_in, den_bit, borrow_in);
        borrow_out = sub.bout;
        rem_out    = keep ? rem_in : sub.diff;
    end
endmodule

// File: rtl/rad_row.sv
module rad_row #(
    parameter int W = 5
) (
    input  logic [W-1:0] part,
    input  logic [W-1:0] den,
    output logic         q_bit,
    output logic [W-2:0] rem_out
);
    logic [W:0]   borrow;
    logic [W-1:0] cell_out;
    logic         keep;
    logic         msb_unused;

    assign borrow[0] = 1'b0;
    assign keep      = borrow[W];
    assign q_bit     = ~keep;

    for (genvar c = 0; c < W; c++) begin : g_col
        rad_cell u_cell (
            .rem_in    (part[c]),
            .den_bit   (den[c]),
            .borrow_in (borrow[c]),
            .keep      (keep),
            .borrow_out(borrow[c+1]),
            .rem_out   (cell_out[c])
        );
    end

    assign rem_out    = cell_out[W-2:0];
    assign msb_unused = cell_out[W-1];
endmodule

// File: rtl/rad_divider.sv
module rad_divider #(
    parameter int NUM_W = 8,
    parameter int DEN_W = 4
) (
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic [NUM_W-1:0] quotient,
    output logic [DEN_W-1:0] remainder,
    output logic             div_zero
);
    localparam int ROW_W = DEN_W + 1;

    logic [DEN_W-1:0] rem_chain [NUM_W+1];
    logic [ROW_W-1:0] den_wide;

    assign den_wide     = {1'b0, divisor};
    assign rem_chain[0] = '0;

    for (genvar i = 0; i < NUM_W; i++) begin : g_row
        rad_row #(.W(ROW_W)) u_row (
            .part   ({rem_chain[i], dividend[NUM_W-1-i]}),
            .den    (den_wide),
            .q_bit  (quotient[NUM_W-1-i]),
            .rem_out(rem_chain[i+1])
        );
    end

    assign remainder = rem_chain[NUM_W];
    assign div_zero  = (divisor == '0);
endmodule

module rad_divider_chk #(
    parameter int NUM_W = 8,
    parameter int DEN_W = 4
) (
    input logic [NUM_W-1:0] dividend,
    input logic [DEN_W-1:0] divisor,
    input logic [NUM_W-1:0] quotient,
    input logic [DEN_W-1:0] remainder,
    input logic             div_zero
);
    logic known;
    assign known = !$isunknown({dividend, divisor, quotient, remainder, div_zero});

    always_comb begin
        if (known && divisor != '0) begin
            // R1
            quot_value_chk: assert (quotient == NUM_W'(dividend / NUM_W'(divisor)));
            // R2
            rem_value_chk: assert (remainder == DEN_W'(dividend % NUM_W'(divisor)));
            // R3
            rem_bound_chk: assert (remainder < divisor);
        end
        if (known) begin
            // R4
            dbz_flag_chk: assert (div_zero == (divisor == '0));
        end
        if (known && divisor == DEN_W'(1)) begin
            // R5
            unit_div_chk: assert (quotient == dividend && remainder == '0);
        end
        if (known && divisor != '0 && NUM_W'(divisor) > dividend) begin
            // R6
            small_num_chk: assert (quotient == '0 && NUM_W'(remainder) == dividend);
        end
    end
endmodule

bind rad_divider rad_divider_chk #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_chk (.*);

// File: tb/rad_divider_tb.sv
`timescale 1ns/1ps
module rad_divider_tb;
    localparam int NUM_W = 8;
    localparam int DEN_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NUM_W-1:0] dividend = '0;
    logic [DEN_W-1:0] divisor  = 4'd1;
    logic [NUM_W-1:0] quotient;
    logic [DEN_W-1:0] remainder;
    logic             div_zero;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    rad_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_dut (
        .dividend (dividend),
        .divisor  (divisor),
        .quotient (quotient),
        .remainder(remainder),
        .div_zero (div_zero)
    );

    function automatic int exp_q(int n, int d);
        return n / d;
    endfunction

    function automatic int exp_r(int n, int d);
        return n % d;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (n=%0d d=%0d)", tag, act, exp, dividend, divisor);
        end
    endtask

    task automatic apply(int n, int d);
        @(negedge clk);
        dividend = NUM_W'(n);
        divisor  = DEN_W'(d);
        #1;
        chk("R4 div_zero", int'(div_zero), (d == 0) ? 1 : 0);
        if (d != 0) begin
            chk("R1 quotient", int'(quotient), exp_q(n, d));
            chk("R2 remainder", int'(remainder), exp_r(n, d));
            chk("R3 remainder below divisor", (remainder < divisor) ? 1 : 0, 1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // first operands settle with no clock edge: R7
        dividend = 8'd200;
        divisor  = 4'd7;
        #0.5;
        chk("R7 settle without clock q", int'(quotient), 28);
        chk("R7 settle without clock r", int'(remainder), 4);

        // R5 divisor of one
        for (int n = 0; n < 256; n += 51) begin
            apply(n, 1);
            chk("R5 quotient equals dividend", int'(quotient), n);
            chk("R5 remainder zero", int'(remainder), 0);
        end
        // R6 dividend below divisor
        for (int n = 0; n < 15; n += 3) begin
            apply(n, 15);
            chk("R6 quotient zero", int'(quotient), 0);
            chk("R6 remainder equals dividend", int'(remainder), n);
        end
        // corners
        apply(255, 15);
        apply(255, 1);
        apply(0, 15);
        apply(128, 9);
        apply(200, 0);
        apply(0, 0);
        // exhaustive sweep
        for (int d = 0; d < 16; d++)
            for (int n = 0; n < 256; n++)
                apply(n, d);
        // seeded random pass
        void'($urandom(32'd20240611));
        for (int k = 0; k < 500; k++)
            apply(int'($urandom_range(255, 0)), int'($urandom_range(15, 0)));
        finish_run();
    end
endmodule